// File: doc/BRIEF.md
# Lane Ultra-Low-Power State Sequencer

This block steps the clock lane or the data lanes of a serial display PHY into and out of the ultra-low-power state. A host issues a one-cycle command that names the lane group (clock or data), the direction (enter or leave) and the number of active data lanes. The block then drives four control bits toward the PHY: a request bit and an exit bit for each lane group. It reads back a 16-bit status word from the PHY and reports the outcome through a one-cycle `done` pulse and a 2-bit result code.

An entry command sets the request bit of the chosen group and completes at once. An exit command first checks PLL lock (status bit 0) and fails at once if the PLL is not locked. If the PLL is locked, the block raises the exit bit and polls the status word until every bit of a lane-dependent mask reads back set. A bounded poll limit applies. After the mask matches, the block holds the exit for one millisecond, measured by a counter scaled from the clock frequency in kHz. When the hold ends it checks the status once more and then drops both bits of the group. Commands that arrive while a sequence is running are discarded.

Top module: `ulps_seq`

## Requirements
- R1: After reset `ctrl`, `busy`, `done`, `err` and `lane_field` are all zero.
- R2: An entry command accepted while idle sets the request bit (bit 0 for the clock lane, bit 2 for the data lanes) at that clock edge. At the same edge it pulses `done` with `err` = 0 (success) and leaves the other control bits unchanged.
- R3: Each accepted command stores its lane count as count−1 on `lane_field`. A count of zero counts as one lane, and a count above `MAX_LANES` is clamped to `MAX_LANES`.
- R4: An exit command accepted while status bit 0 is clear pulses `done` at that edge with `err` = 1 (PLL not locked) and leaves `ctrl` unchanged.
- R5: An exit command accepted while status bit 0 is set raises the exit bit of its group (bit 1 for the clock lane, bit 3 for the data lanes). `busy` then stays high until the sequence ends, and the request bit stays as it was.
- R6: The data-lane mask holds status bit 5 for one lane, adds bit 8 for two lanes, bit 10 for three and bit 12 for four. The clock-lane mask is bit 3 alone. A match needs every mask bit set, and status bits outside the mask have no effect.
- R7: If the mask does not match within `POLL_LIMIT` clock edges after acceptance, `done` pulses at acceptance + `POLL_LIMIT` with `err` = 2 (timeout), and the request and exit bits remain set.
- R8: Once the mask matches, the exit is held for `CLK_KHZ` cycles (one millisecond). If the status matches from the start, `done` pulses at acceptance + 1 + `CLK_KHZ` with `err` = 0, and both bits of the group are cleared at that edge.
- R9: If the mask no longer matches at the last hold cycle, the sequence ends with `err` = 2 and both bits of the group stay set.
- R10: A command presented while `busy` is high is ignored. This includes the cycle in which the hold expires: the command changes no control bit and produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_exit | input | 1 | 1 = leave the low-power state, 0 = enter it |
| cmd_clk | input | 1 | 1 = clock lane, 0 = data lanes |
| lane_req | input | 3 | Requested active data-lane count |
| stat | input | 16 | PHY status word (bit 0 PLL lock, bit 3 clock lane stop, bits 5/8/10/12 data lane stop) |
| ctrl | output | 4 | Control bits: 0 clock request, 1 clock exit, 2 data request, 3 data exit |
| lane_field | output | 2 | Stored active lane count minus one |
| busy | output | 1 | An exit sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Result of the last command: 0 ok, 1 PLL not locked, 2 timeout |

## Verification
Two functions can land on the same clock edge: the expiry of the one-millisecond hold and the arrival of a new command. The bench places an entry command exactly on the edge where the hold ends. It requires one `done` carrying the exit result, with the control bits cleared and the stray request bit never set. A second collision pairs the hold expiry with the final status check: the stop bit is dropped partway through the hold, and the bench expects a timeout code with both bits still set.

// File: rtl/ulps_seq.sv
module ulps_seq #(
  parameter int CLK_KHZ    = 250000,
  parameter int POLL_LIMIT = 4096,
  parameter int MAX_LANES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_exit,
  input  logic        cmd_clk,
  input  logic [2:0]  lane_req,
  input  logic [15:0] stat,
  output logic [3:0]  ctrl,
  output logic [1:0]  lane_field,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err
);
  localparam int CNT_MAX = (CLK_KHZ > POLL_LIMIT) ? CLK_KHZ : POLL_LIMIT;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [2:0] LANE_CAP = 3'(MAX_LANES);
  localparam logic [CW-1:0] POLL_END = CW'(POLL_LIMIT - 1);
  localparam logic [CW-1:0] HOLD_END = CW'(CLK_KHZ - 1);
  localparam logic [1:0] E_OK = 2'd0, E_PLL = 2'd1, E_TO = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_POLL, S_HOLD} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic           on_clk;
  logic [2:0]     lanes_c;
  logic [15:0]    mask;
  logic           hit;

  assign lanes_c = (lane_req == 3'd0) ? 3'd1 :
                   (lane_req > LANE_CAP) ? LANE_CAP : lane_req;

  assign mask = on_clk ? 16'h0008 :
                (16'h0020
                 | ((lane_field >= 2'd1) ? 16'h0100 : 16'h0000)
                 | ((lane_field >= 2'd2) ? 16'h0400 : 16'h0000)
                 | ((lane_field == 2'd3) ? 16'h1000 : 16'h0000));

  assign hit  = (stat & mask) == mask;
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      on_clk     <= 1'b0;
      ctrl       <= 4'h0;
      lane_field <= 2'd0;
      done       <= 1'b0;
      err        <= E_OK;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          lane_field <= 2'(lanes_c - 3'd1);
          on_clk     <= cmd_clk;
          if (!cmd_exit) begin
            ctrl <= ctrl | (cmd_clk ? 4'b0001 : 4'b0100);
            done <= 1'b1;
            err  <= E_OK;
          end else if (!stat[0]) begin
            done <= 1'b1;
            err  <= E_PLL;
          end else begin
            ctrl <= ctrl | (cmd_clk ? 4'b0010 : 4'b1000);
            err  <= E_OK;
            cnt  <= '0;
            st   <= S_POLL;
          end
        end
        S_POLL: begin
          if (hit) begin
            cnt <= '0;
            st  <= S_HOLD;
          end else if (cnt == POLL_END) begin
            done <= 1'b1;
            err  <= E_TO;
            st   <= S_IDLE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_HOLD: begin
          if (cnt == HOLD_END) begin
            done <= 1'b1;
            st   <= S_IDLE;
            if (hit) begin
              ctrl <= ctrl & (on_clk ? 4'b1100 : 4'b0011);
              err  <= E_OK;
            end else begin
              err  <= E_TO;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ulps_seq_chk.sv
module ulps_seq_chk #(
  parameter int CLK_KHZ    = 250000,
  parameter int POLL_LIMIT = 4096,
  parameter int MAX_LANES  = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_exit,
  input logic [15:0] stat,
  input logic [3:0]  ctrl,
  input logic [1:0]  lane_field,
  input logic        busy,
  input logic        done,
  input logic [1:0]  err
);
  int run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else        run <= busy ? run + 1 : 0;
  end

  AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lane_field) <= MAX_LANES - 1); // R3

  AST_PLL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_exit && !stat[0]) |=> (done && err == 2'd1)); // R4

  AST_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stat[0]) && (ctrl[1] || ctrl[3]))); // R5

  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || $stable(ctrl))); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run <= POLL_LIMIT + CLK_KHZ + 1); // R8
endmodule

bind ulps_seq ulps_seq_chk #(
  .CLK_KHZ(CLK_KHZ), .POLL_LIMIT(POLL_LIMIT), .MAX_LANES(MAX_LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_exit(cmd_exit),
  .stat(stat), .ctrl(ctrl), .lane_field(lane_field), .busy(busy),
  .done(done), .err(err)
);

// File: tb/ulps_seq_tb.sv
module ulps_seq_tb;
  localparam int H = 40;
  localparam int P = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_exit = 1'b0, cmd_clk = 1'b0;
  logic [2:0]  lane_req = 3'd1;
  logic [15:0] stat = 16'h0;
  logic [3:0]  ctrl;
  logic [1:0]  lane_field, err;
  logic        busy, done;

  ulps_seq #(.CLK_KHZ(H), .POLL_LIMIT(P), .MAX_LANES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_exit(cmd_exit),
    .cmd_clk(cmd_clk), .lane_req(lane_req), .stat(stat), .ctrl(ctrl),
    .lane_field(lane_field), .busy(busy), .done(done), .err(err));

  always #2 clk = ~clk;

  typedef struct {
    int          at;
    logic [3:0]  c;
    logic [1:0]  e;
    logic [1:0]  f;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0, nchk = 0, nfail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && done) begin
    nchk++;
    if (q.size() == 0) begin
      nfail++;
      $display("FAIL R10 unexpected done at %0d: ctrl=%h err=%0d, expected no done", cyc, ctrl, err);
    end else begin
      exp_t x;
      x = q.pop_front();
      if (cyc != x.at || ctrl != x.c || err != x.e || lane_field != x.f) begin
        nfail++;
        $display("FAIL %s: cyc=%0d ctrl=%h err=%0d field=%0d, expected cyc=%0d ctrl=%h err=%0d field=%0d",
                 x.req, cyc, ctrl, err, lane_field, x.at, x.c, x.e, x.f);
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic issue(input logic ex, input logic ck, input logic [2:0] ln, input int lat,
                       input logic [3:0] ec, input logic [1:0] ee, input logic [1:0] ef,
                       input string req);
    exp_t x;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_exit = ex; cmd_clk = ck; lane_req = ln;
    x.at = cyc + 1 + lat; x.c = ec; x.e = ee; x.f = ef; x.req = req;
    q.push_back(x);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic stray_enter();
    cmd_valid = 1'b1; cmd_exit = 1'b0; cmd_clk = 1'b0; lane_req = 3'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 20000) begin
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ctrl == 0 && busy == 0 && done == 0 && err == 0 && lane_field == 0,
        "R1 reset", {ctrl, busy, done, err, lane_field}, 0);
    rst_n = 1'b1;

    issue(0, 0, 3'd2, 0, 4'h4, 2'd0, 2'd1, "R2 enter data");
    drain();

    stat = 16'h0121;
    issue(1, 0, 3'd2, 1 + H, 4'h0, 2'd0, 2'd1, "R8 exit data two lanes");
    repeat (3) @(negedge clk);
    chk(busy && ctrl == 4'hC, "R5 exit bit raised", {busy, ctrl}, {1'b1, 4'hC});
    drain();

    issue(0, 0, 3'd4, 0, 4'h4, 2'd0, 2'd1, "R3 clamp high");
    drain();

    stat = 16'h0120;
    issue(1, 0, 3'd2, 0, 4'h4, 2'd1, 2'd1, "R4 no lock");
    drain();

    stat = 16'h7E21;
    issue(1, 0, 3'd2, P, 4'hC, 2'd2, 2'd1, "R7 R6 timeout bit8 missing");
    drain();

    stat = 16'h0121;
    issue(1, 0, 3'd2, 1 + H, 4'h0, 2'd0, 2'd1, "R8 retry");
    drain();

    issue(0, 0, 3'd0, 0, 4'h4, 2'd0, 2'd0, "R3 clamp low");
    drain();
    stat = 16'h0021;
    issue(1, 0, 3'd1, 1 + H, 4'h0, 2'd0, 2'd0, "R6 one lane mask");
    drain();

    issue(0, 1, 3'd1, 0, 4'h1, 2'd0, 2'd0, "R2 enter clock");
    drain();
    stat = 16'h0009;
    issue(1, 1, 3'd1, 1 + H, 4'h0, 2'd0, 2'd0, "R10 exit clock");
    repeat (4) @(negedge clk);
    stray_enter();
    drain();
    chk(ctrl == 4'h0, "R10 busy command dropped", ctrl, 0);

    issue(0, 1, 3'd1, 0, 4'h1, 2'd0, 2'd0, "R2 enter clock again");
    drain();
    issue(1, 1, 3'd1, 1 + H, 4'h3, 2'd2, 2'd0, "R9 status lost in hold");
    repeat (10) @(negedge clk);
    stat = 16'h0001;
    drain();

    stat = 16'h0009;
    issue(1, 1, 3'd1, 1 + H, 4'h0, 2'd0, 2'd0, "R10 exit with collision");
    repeat (H) @(negedge clk);
    stray_enter();
    drain();
    chk(ctrl == 4'h0 && !busy, "R10 hold-end command dropped", {busy, ctrl}, 0);

    finish_run();
  end
endmodule